// File: doc/BRIEF.md
# Bundle Next-PC Sequencer with Hardware Repeat Loop

This block owns the program counter of a core that fetches one 64-bit instruction bundle per step. It reads the two format bits of each bundle to decide how the two 32-bit halves are issued. It routes the halves into first-issued and second-issued order. It combines the jump targets that the execution slots report into a single redirect. The execution units themselves live outside the block. Each slot reports "no jump" by driving an all-ones sentinel address.

The block keeps a zero-overhead repeat loop. The loop start and end addresses come in from outside. The iteration count is held inside the block, and a repeat-active flag lives in the status word. Whether the count is nonzero is sampled before the step. The count decrements when the end address is reached, and the flag drops once the count runs out. A taken jump outranks the loop-back.

An instruction-address breakpoint is also handled. When the executed address matches the breakpoint and debug is enabled, the block saves the would-be next PC and the status word. It then masks the status word and sends execution to a fixed debug vector. A load strobe sets the PC, count and status before a program runs.

Top module: `zol_seq`

## Requirements
- R1: The format is {bundle[63], bundle[31]}. Code 3 is a long instruction, 0 is parallel issue, 1 is upper half first, and 2 is lower half first; `fmt_kind` shows that code. `first_half` is bundle[31:0] for code 2 and bundle[63:32] otherwise. `second_half` is the other half.
- R2: In codes 1 and 2, `skip_second` is 1 when the first-issued slot reports a target or `kill_first` is high. The second slot's target is then ignored. For code 1 the upper half is slot A; for code 2 the lower half is slot B.
- R3: On a step, the count decrements by one (modulo 2^CNT_W) only when the PC equals `loop_end` and either the count is nonzero or the repeat flag (status bit 4) is set. Otherwise it is unchanged.
- R4: On a step, the repeat flag clears when it was set, the PC equals `loop_end`, and the decremented count is zero.
- R5: The next PC is chosen in this order: a valid jump target first, then `loop_start` on a loop-back, then PC+8.
- R6: A loop-back needs three things: the repeat flag set before the step, a count that was nonzero before the decrement, and the PC at `loop_end`. A count of 1 therefore still loops back once.
- R7: In code 0, when both slots report targets, `par_err` is 1 and no jump is taken.
- R8: In code 3, only slot A's target is used.
- R9: When the PC equals `brk_addr` and debug-enable (status bit 1) is set, the step does the following. It stores the computed next PC in `dbg_pc`. It stores the status word, with EA (bit 3) set, in `dbg_stat`. It keeps only SM (bit 0) of the status word and sets DS (bit 2). It loads the PC with the debug vector.
- R10: Reset gives PC = RESET_PC and zero count, status and debug registers. `ld_en` loads PC, count and status and takes priority over `step`.
- R11: With `step` and `ld_en` both low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Retire the current bundle this cycle |
| bundle | input | 64 | Fetched bundle at the current PC |
| jmp_a | input | 32 | Slot A (upper half / long) target, all-ones for none |
| jmp_b | input | 32 | Slot B (lower half) target, all-ones for none |
| kill_first | input | 1 | First-issued half cancels the second |
| loop_start | input | 32 | Repeat loop first address |
| loop_end | input | 32 | Repeat loop last address |
| brk_addr | input | 32 | Instruction breakpoint address |
| ld_en | input | 1 | Load PC, count and status |
| ld_pc | input | 32 | PC load value |
| ld_cnt | input | 16 | Count load value |
| ld_stat | input | 8 | Status load value |
| pc | output | 32 | Current program counter |
| cnt | output | 16 | Repeat count |
| stat | output | 8 | Status word |
| dbg_pc | output | 32 | Saved next PC on breakpoint |
| dbg_stat | output | 8 | Saved status on breakpoint |
| fmt_kind | output | 2 | Decoded format code |
| first_half | output | 32 | Half issued first |
| second_half | output | 32 | Half issued second |
| skip_second | output | 1 | Second half suppressed |
| par_err | output | 1 | Both parallel slots jumped |

## Verification
Random steps start from a loaded PC that sits at the loop end, at the breakpoint, or at a random address. They use random formats, sentinel-heavy jump targets, counts of 0 to 3 and random status bits. These runs separate the count-sampling order from the decrement order, and they separate the jump-over-loop priority. Directed cases cover the following:
- a full three-pass loop that ends with the flag clearing;
- a count of zero with the flag set, which wraps the count;
- a breakpoint at the loop end, which shows the saved PC is the loop-back address;
- both parallel slots jumping;
- idle cycles that must hold state.

// File: rtl/zol_pkg.sv
// Shared types and status-bit positions for the bundle sequencer.
// Assumes an 8-bit status word; bit positions below are fixed by design.
package zol_pkg;
    typedef enum logic [1:0] {
        FMT_PAR  = 2'd0,
        FMT_UF   = 2'd1,   // upper half issued first
        FMT_LF   = 2'd2,   // lower half issued first
        FMT_LONG = 2'd3
    } fmt_e;

    localparam int STAT_W = 8;
    localparam int ST_SM  = 0;
    localparam int ST_DB  = 1;
    localparam int ST_DS  = 2;
    localparam int ST_EA  = 3;
    localparam int ST_RP  = 4;
endpackage

// File: rtl/zol_fmt_merge.sv
// Decodes bundle format bits, orders the two halves and merges slot jump
// targets into one redirect. Assumes the all-ones address means "no jump".
module zol_fmt_merge
    import zol_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [63:0]   bundle,
    input  logic [AW-1:0] jmp_a,
    input  logic [AW-1:0] jmp_b,
    input  logic          kill_first,
    output fmt_e          kind,
    output logic [31:0]   first_half,
    output logic [31:0]   second_half,
    output logic [AW-1:0] tgt,
    output logic          tgt_vld,
    output logic          skip_second,
    output logic          par_err
);
    localparam logic [AW-1:0] NONE = '1;

    logic a_v;
    logic b_v;

    assign a_v  = (jmp_a != NONE);
    assign b_v  = (jmp_b != NONE);
    assign kind = fmt_e'({bundle[63], bundle[31]});

    // Route halves into issue order.
    always_comb begin
        if (kind == FMT_LF) begin
            first_half  = bundle[31:0];
            second_half = bundle[63:32];
        end else begin
            first_half  = bundle[63:32];
            second_half = bundle[31:0];
        end
    end

    // Merge slot targets according to issue mode.
    always_comb begin
        tgt         = jmp_a;
        tgt_vld     = 1'b0;
        skip_second = 1'b0;
        par_err     = 1'b0;
        unique case (kind)
            FMT_LONG: begin
                tgt     = jmp_a;
                tgt_vld = a_v;
            end
            FMT_UF: begin
                if (a_v || kill_first) begin
                    skip_second = 1'b1;
                    tgt         = jmp_a;
                    tgt_vld     = a_v;
                end else begin
                    tgt     = jmp_b;
                    tgt_vld = b_v;
                end
            end
            FMT_LF: begin
                if (b_v || kill_first) begin
                    skip_second = 1'b1;
                    tgt         = jmp_b;
                    tgt_vld     = b_v;
                end else begin
                    tgt     = jmp_a;
                    tgt_vld = a_v;
                end
            end
            default: begin
                if (a_v && b_v) begin
                    par_err = 1'b1;
                end else if (a_v) begin
                    tgt     = jmp_a;
                    tgt_vld = 1'b1;
                end else begin
                    tgt     = jmp_b;
                    tgt_vld = b_v;
                end
            end
        endcase
    end

    // R7: an error only ever accompanies two real targets in parallel mode
    always_comb begin
        AST_PAR_ERR_SRC: assert (!par_err || (kind == FMT_PAR && a_v && b_v)); // R7
    end
endmodule

// File: rtl/zol_rpt_unit.sv
// Repeat-loop arithmetic for one step: count decrement, flag exit and
// loop-back decision. Pure combinational; the count is sampled pre-step.
module zol_rpt_unit #(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input  logic [AW-1:0]    pc,
    input  logic [AW-1:0]    loop_end,
    input  logic [CNT_W-1:0] cnt,
    input  logic             rp,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             rp_nxt,
    output logic             loop_back
);
    logic at_end;
    logic was_nz;

    // Sample end-hit and pre-step count state.
    always_comb begin
        at_end = (pc == loop_end);
        was_nz = (cnt != '0);
    end

    // Decrement, exit and loop-back decisions.
    always_comb begin
        cnt_nxt   = (at_end && (was_nz || rp)) ? cnt - 1'b1 : cnt;
        rp_nxt    = rp && !(at_end && (cnt_nxt == '0));
        loop_back = rp && was_nz && at_end;
    end
endmodule

// File: rtl/zol_dbg_trap.sv
// Instruction-address breakpoint: detects the hit and forms the new status,
// saved status and the vector. Assumes the status word given is post-step.
module zol_dbg_trap
    import zol_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]     pc,
    input  logic [AW-1:0]     brk_addr,
    input  logic [STAT_W-1:0] stat_in,
    output logic              take,
    output logic [STAT_W-1:0] stat_out,
    output logic [STAT_W-1:0] saved_stat
);
    // Hit detection and status masking.
    always_comb begin
        take       = (pc == brk_addr) && stat_in[ST_DB];
        saved_stat = stat_in;
        saved_stat[ST_EA] = 1'b1;
        stat_out   = stat_in;
        if (take) begin
            stat_out        = '0;
            stat_out[ST_SM] = stat_in[ST_SM];
            stat_out[ST_DS] = 1'b1;
        end
    end
endmodule

// File: rtl/zol_seq.sv
// Next-PC sequencer for 64-bit bundles with a hardware repeat loop and an
// instruction breakpoint. Holds PC, count, status and debug save registers;
// one bundle retires per cycle with step high. ld_en outranks step.
module zol_seq
    import zol_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          CNT_W    = 16,
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter logic [31:0] DBG_VEC  = 32'hFFFF_F128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [63:0]       bundle,
    input  logic [AW-1:0]     jmp_a,
    input  logic [AW-1:0]     jmp_b,
    input  logic              kill_first,
    input  logic [AW-1:0]     loop_start,
    input  logic [AW-1:0]     loop_end,
    input  logic [AW-1:0]     brk_addr,
    input  logic              ld_en,
    input  logic [AW-1:0]     ld_pc,
    input  logic [CNT_W-1:0]  ld_cnt,
    input  logic [STAT_W-1:0] ld_stat,
    output logic [AW-1:0]     pc,
    output logic [CNT_W-1:0]  cnt,
    output logic [STAT_W-1:0] stat,
    output logic [AW-1:0]     dbg_pc,
    output logic [STAT_W-1:0] dbg_stat,
    output logic [1:0]        fmt_kind,
    output logic [31:0]       first_half,
    output logic [31:0]       second_half,
    output logic              skip_second,
    output logic              par_err
);
    localparam logic [AW-1:0] STEP_BYTES = AW'(8);

    fmt_e              kind;
    logic [AW-1:0]     tgt;
    logic              tgt_vld;
    logic [CNT_W-1:0]  cnt_nxt;
    logic              rp_nxt;
    logic              loop_back;
    logic [AW-1:0]     npc_seq;
    logic [STAT_W-1:0] stat_mid;
    logic              trap;
    logic [STAT_W-1:0] stat_trap;
    logic [STAT_W-1:0] stat_save;

    zol_fmt_merge #(.AW(AW)) u_fmt (
        .bundle      (bundle),
        .jmp_a       (jmp_a),
        .jmp_b       (jmp_b),
        .kill_first  (kill_first),
        .kind        (kind),
        .first_half  (first_half),
        .second_half (second_half),
        .tgt         (tgt),
        .tgt_vld     (tgt_vld),
        .skip_second (skip_second),
        .par_err     (par_err)
    );

    zol_rpt_unit #(.AW(AW), .CNT_W(CNT_W)) u_rpt (
        .pc        (pc),
        .loop_end  (loop_end),
        .cnt       (cnt),
        .rp        (stat[ST_RP]),
        .cnt_nxt   (cnt_nxt),
        .rp_nxt    (rp_nxt),
        .loop_back (loop_back)
    );

    zol_dbg_trap #(.AW(AW)) u_dbg (
        .pc         (pc),
        .brk_addr   (brk_addr),
        .stat_in    (stat_mid),
        .take       (trap),
        .stat_out   (stat_trap),
        .saved_stat (stat_save)
    );

    assign fmt_kind = kind;

    // Select the sequential next PC and fold the repeat flag into status.
    always_comb begin
        if (tgt_vld)        npc_seq = tgt;
        else if (loop_back) npc_seq = loop_start;
        else                npc_seq = pc + STEP_BYTES;
        stat_mid        = stat;
        stat_mid[ST_RP] = rp_nxt;
    end

    // State registers: reset, load, or retire one bundle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= AW'(RESET_PC);
            cnt      <= '0;
            stat     <= '0;
            dbg_pc   <= '0;
            dbg_stat <= '0;
        end else if (ld_en) begin
            pc   <= ld_pc;
            cnt  <= ld_cnt;
            stat <= ld_stat;
        end else if (step) begin
            cnt  <= cnt_nxt;
            stat <= stat_trap;
            if (trap) begin
                pc       <= AW'(DBG_VEC);
                dbg_pc   <= npc_seq;
                dbg_stat <= stat_save;
            end else begin
                pc <= npc_seq;
            end
        end
    end

    AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_en && pc == loop_end && (cnt != '0 || stat[ST_RP]))
        |=> (cnt == $past(cnt) - 1'b1)); // R3

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_en && pc != loop_end) |=> $stable(cnt)); // R3

    AST_RP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_en && pc == loop_end && stat[ST_RP] && cnt == CNT_W'(1))
        |=> !stat[ST_RP]); // R4

    AST_TRAP_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_en && pc == brk_addr && stat[ST_DB])
        |=> (stat[ST_DS] && pc == AW'(DBG_VEC) && dbg_stat[ST_EA])); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ld_en) |=> ($stable(pc) && $stable(cnt) && $stable(stat))); // R11
endmodule

// File: tb/zol_seq_bench.sv
module zol_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] NONE = 32'hFFFF_FFFF;
    localparam logic [31:0] VEC  = 32'hFFFF_F128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [63:0] bundle = '0;
    logic [31:0] jmp_a = NONE, jmp_b = NONE;
    logic        kill_first = 1'b0;
    logic [31:0] loop_start = 32'h100, loop_end = 32'h110, brk_addr = 32'h500;
    logic        ld_en = 1'b0;
    logic [31:0] ld_pc = '0;
    logic [15:0] ld_cnt = '0;
    logic [7:0]  ld_stat = '0;
    logic [31:0] pc, dbg_pc;
    logic [15:0] cnt;
    logic [7:0]  stat, dbg_stat;
    logic [1:0]  fmt_kind;
    logic [31:0] first_half, second_half;
    logic        skip_second, par_err;

    int total = 0;
    int bad   = 0;

    logic [31:0] m_pc, m_dpc;
    logic [15:0] m_cnt;
    logic [7:0]  m_stat, m_dstat;

    zol_seq u_zol_seq (
        .clk(clk), .rst_n(rst_n), .step(step), .bundle(bundle),
        .jmp_a(jmp_a), .jmp_b(jmp_b), .kill_first(kill_first),
        .loop_start(loop_start), .loop_end(loop_end), .brk_addr(brk_addr),
        .ld_en(ld_en), .ld_pc(ld_pc), .ld_cnt(ld_cnt), .ld_stat(ld_stat),
        .pc(pc), .cnt(cnt), .stat(stat), .dbg_pc(dbg_pc), .dbg_stat(dbg_stat),
        .fmt_kind(fmt_kind), .first_half(first_half), .second_half(second_half),
        .skip_second(skip_second), .par_err(par_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Expected target merge from requirements R2, R7 and R8.
    function automatic logic [32:0] exp_tgt(logic [1:0] f, logic [31:0] a,
                                            logic [31:0] b, logic k);
        logic av = (a != NONE);
        logic bv = (b != NONE);
        case (f)
            2'd3: return {av, a};
            2'd1: return av ? {1'b1, a} : (k ? 33'd0 : {bv, b});
            2'd2: return bv ? {1'b1, b} : (k ? 33'd0 : {av, a});
            default: return (av && bv) ? 33'd0 : (av ? {1'b1, a} : {bv, b});
        endcase
    endfunction

    // Reference step from R3..R6 and R9.
    task automatic model_step();
        logic [1:0]  f = {bundle[63], bundle[31]};
        logic [32:0] t = exp_tgt(f, jmp_a, jmp_b, kill_first);
        logic        rp0 = m_stat[4];
        logic        nz  = (m_cnt != 0);
        logic        hit = (m_pc == loop_end);
        logic [31:0] npc;
        if (hit && (nz || rp0)) m_cnt = m_cnt - 16'd1;
        if (rp0 && hit && m_cnt == 0) m_stat[4] = 1'b0;
        if (t[32])                 npc = t[31:0];
        else if (rp0 && nz && hit) npc = loop_start;
        else                       npc = m_pc + 32'd8;
        if (m_pc == brk_addr && m_stat[1]) begin
            m_dpc   = npc;
            m_dstat = m_stat | 8'h08;
            m_stat  = (m_stat & 8'h01) | 8'h04;
            m_pc    = VEC;
        end else begin
            m_pc = npc;
        end
    endtask

    task automatic do_load(logic [31:0] p, logic [15:0] c, logic [7:0] s);
        @(negedge clk);
        ld_en = 1'b1; ld_pc = p; ld_cnt = c; ld_stat = s; step = 1'b0;
        @(negedge clk);
        ld_en = 1'b0;
        m_pc = p; m_cnt = c; m_stat = s;
        check("R10 load pc", pc, p);
        check("R10 load cnt", cnt, c);
    endtask

    // Drive bundle and slots, check decode, step once, check state.
    task automatic do_step(logic [63:0] bdl, logic [31:0] a, logic [31:0] b, logic k);
        logic [1:0]  f;
        logic [32:0] t;
        bundle = bdl; jmp_a = a; jmp_b = b; kill_first = k;
        f = {bdl[63], bdl[31]};
        t = exp_tgt(f, a, b, k);
        #1;
        check("R1 fmt", fmt_kind, f);
        check("R1 first", first_half, (f == 2'd2) ? bdl[31:0] : bdl[63:32]);
        check("R1 second", second_half, (f == 2'd2) ? bdl[63:32] : bdl[31:0]);
        check("R2 skip", skip_second,
              ((f == 2'd1) && (a != NONE || k)) || ((f == 2'd2) && (b != NONE || k)));
        check("R7 par_err", par_err, (f == 2'd0) && (a != NONE) && (b != NONE));
        step = 1'b1;
        model_step();
        @(negedge clk);
        step = 1'b0;
        check("R5 pc", pc, m_pc);
        check("R3 cnt", cnt, m_cnt);
        check("R4 stat", stat, m_stat);
        check("R9 dbg_pc", dbg_pc, m_dpc);
        check("R9 dbg_stat", dbg_stat, m_dstat);
    endtask

    function automatic logic [63:0] mk_bundle(logic [1:0] f);
        logic [63:0] v = {$urandom(), $urandom()};
        v[63] = f[1];
        v[31] = f[0];
        return v;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        m_dpc = '0; m_dstat = '0;
        repeat (3) @(negedge clk);
        check("R10 reset pc", pc, 32'h0);
        check("R10 reset cnt", cnt, 16'h0);
        check("R10 reset stat", stat, 8'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: three-pass loop over 0x100..0x110 with count 2
        do_load(32'h100, 16'd2, 8'h10);
        for (int i = 0; i < 9; i++) do_step(mk_bundle(2'd3), NONE, NONE, 1'b0);
        check("R6 loop exit pc", pc, 32'h118);
        check("R4 flag cleared", stat[4], 1'b0);
        check("R6 cnt final", cnt, 16'd0);

        // R6: count 1 still loops back
        do_load(32'h110, 16'd1, 8'h10);
        do_step(mk_bundle(2'd1), NONE, NONE, 1'b0);
        check("R6 cnt1 loop back", pc, 32'h100);

        // R3: zero count with flag set wraps
        do_load(32'h110, 16'd0, 8'h10);
        do_step(mk_bundle(2'd1), NONE, NONE, 1'b0);
        check("R3 wrap cnt", cnt, 16'hFFFF);
        check("R6 no loop at zero", pc, 32'h118);

        // R5: jump outranks loop-back
        do_load(32'h110, 16'd3, 8'h10);
        do_step(mk_bundle(2'd3), 32'h4000, NONE, 1'b0);
        check("R5 jump wins", pc, 32'h4000);

        // R8: long ignores slot B
        do_load(32'h200, 16'd0, 8'h00);
        do_step(mk_bundle(2'd3), NONE, 32'h7000, 1'b0);
        check("R8 long ignores B", pc, 32'h208);

        // R7: both parallel slots jump
        do_load(32'h200, 16'd0, 8'h00);
        do_step(mk_bundle(2'd0), 32'h3000, 32'h5000, 1'b0);
        check("R7 no jump", pc, 32'h208);

        // R2: kill suppresses the second target
        do_load(32'h200, 16'd0, 8'h00);
        do_step(mk_bundle(2'd2), 32'h3000, NONE, 1'b1);
        check("R2 kill ignores A", pc, 32'h208);

        // R9: breakpoint at loop end saves loop start
        brk_addr = 32'h110;
        do_load(32'h110, 16'd2, 8'h13);
        do_step(mk_bundle(2'd1), NONE, NONE, 1'b0);
        check("R9 vector", pc, VEC);
        check("R9 saved pc", dbg_pc, 32'h100);
        check("R9 stat", stat, 8'h05);

        // R11: idle cycles hold state
        repeat (3) @(negedge clk);
        check("R11 hold pc", pc, VEC);
        check("R11 hold cnt", cnt, 16'd1);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] p;
            logic [31:0] a;
            logic [31:0] b;
            int sel = $urandom_range(0, 9);
            loop_start = {$urandom_range(0, 255), 3'b000};
            loop_end   = {$urandom_range(0, 255), 3'b000};
            brk_addr   = ($urandom_range(0, 3) == 0) ? loop_end
                                                     : {$urandom_range(0, 255), 3'b000};
            if (sel < 5)      p = loop_end;
            else if (sel < 7) p = brk_addr;
            else              p = {$urandom_range(0, 255), 3'b000};
            a = ($urandom_range(0, 2) == 0) ? {$urandom_range(0, 4095), 3'b000} : NONE;
            b = ($urandom_range(0, 2) == 0) ? {$urandom_range(0, 4095), 3'b000} : NONE;
            do_load(p, 16'($urandom_range(0, 3)), 8'($urandom()));
            do_step(mk_bundle(2'($urandom_range(0, 3))), a, b, 1'($urandom()));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule